// File: doc/BRIEF.md
# DDR SDRAM Read Burst Engine

This block is the device-side read path of a double-data-rate SDRAM, written as a synthesizable model. It takes decoded READ commands on the clock, each carrying a bank, a starting column and an auto-precharge flag. After the programmed CAS latency it returns the burst as one pair of data elements per clock: one element for the rising edge and one for the falling edge. It drives the data strobe with a one-cycle preamble. Its output enables show when the bus is driven and when it is released.

A READ may be issued on any clock. A later READ truncates the burst in progress, or chains onto the end of a finished one, and the data stream has no gap. When a burst that was not truncated ends with auto precharge selected, the block pulses a precharge request carrying the bank number. Data is generated from the bank and column, so the stream can be checked without any storage.

Top module: `ddr_rd_engine`

## Requirements
- R1: While reset is asserted and after it is released, with no command issued, dq_oe_o, dqs_oe_o, dqs_rise_o and pre_req_o are all low.
- R2: A READ sampled in cycle n puts its first element pair on the outputs in cycle n+2 when cl_sel_i=0, and in cycle n+3 when cl_sel_i=1. The burst's pairs then follow in consecutive cycles.
- R3: bl_sel_i picks the burst length: 0 gives 2 elements, 1 gives 4, and 2 or 3 give 8. For burst length BL and start column C, element i uses column (C & ~(BL-1)) | ((C+i) & (BL-1)). Pair j carries element 2j on dq_rise_o and element 2j+1 on dq_fall_o.
- R4: The value of an element for bank B and column K is the low DQ_W bits of K XOR (B << (DQ_W-2)).
- R5: In every data cycle dqs_oe_o=1, dqs_rise_o=1 and dqs_fall_o=0, so the strobe is low with each falling-edge element, including the last one (the postamble). When a cycle holds no data but the next cycle does, that cycle is a preamble: dqs_oe_o=1, dqs_rise_o=0, dqs_fall_o=0 and dq_oe_o=0.
- R6: In a cycle with no data, dq_oe_o is 0. dqs_oe_o is 0 unless the cycle is a preamble.
- R7: A READ whose data starts while an earlier burst is in progress replaces that burst from its own first data cycle on. A READ issued x cycles after the previous one leaves exactly x pairs of the earlier burst, with no idle cycle between them.
- R8: A burst issued with ap_i=1 that completes all its pairs raises pre_req_o for exactly one cycle, the cycle after its last pair, with pre_bank_o equal to its bank. This holds even when a chained burst starts in that cycle.
- R9: A burst with ap_i=1 that is truncated by a later READ never raises pre_req_o.
- R10: A burst issued with ap_i=0 never raises pre_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cl_sel_i | input | 1 | CAS latency: 0 gives 2, 1 gives 3; held stable while reads are in flight |
| bl_sel_i | input | 2 | Burst length: 0 gives 2, 1 gives 4, 2 or 3 give 8; held stable while reads are in flight |
| cmd_rd_i | input | 1 | READ command in this cycle |
| bank_i | input | 2 | Bank address of the READ |
| col_i | input | COL_W | Starting column of the READ |
| ap_i | input | 1 | Auto precharge requested (address bit 10 of the command) |
| dq_rise_o | output | DQ_W | Rising-edge data element |
| dq_fall_o | output | DQ_W | Falling-edge data element |
| dq_oe_o | output | 1 | Data output enable |
| dqs_rise_o | output | 1 | Strobe level during the rising half of the cycle |
| dqs_fall_o | output | 1 | Strobe level during the falling half of the cycle |
| dqs_oe_o | output | 1 | Strobe output enable |
| pre_req_o | output | 1 | One-cycle precharge request |
| pre_bank_o | output | 2 | Bank to precharge |

## Verification
The bench targets several corner cases. One is truncation at different distances into an 8-element burst: a design that cut the old burst one cycle early or late would show a gap, a repeated pair, or the wrong pair count. Another is chaining with no gap right after a finished burst that had auto precharge selected: a design that treated this as truncation would lose the precharge pulse, and one that missed a truncated burst would send a false pulse. Unaligned start columns in every burst length exercise the wrap inside the aligned block, which a plain incrementer would get wrong. A single idle cycle between two bursts must become a preamble, and a design that left the strobe released there, or drove it during a seamless chain, would fail the strobe-enable comparison.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int BANK_W = 2;
  localparam int PAIR_W = 2;

  typedef enum logic {CAS2 = 1'b0, CAS3 = 1'b1} cas_e;
  typedef enum logic [1:0] {
    BURST2  = 2'd0,
    BURST4  = 2'd1,
    BURST8  = 2'd2,
    BURST8R = 2'd3
  } blen_e;

  // index of the final element pair of a burst
  function automatic logic [PAIR_W-1:0] last_pair(blen_e b);
    case (b)
      BURST2:  return 2'd0;
      BURST4:  return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_cmd_pipe.sv
module ddr_rd_cmd_pipe
  import ddr_rd_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int DEPTH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         vld_i,
  input  logic [BANK_W-1:0]            bank_i,
  input  logic [COL_W-1:0]             col_i,
  input  logic                         ap_i,
  output logic [DEPTH-1:0]             vld_o,
  output logic [DEPTH-1:0][BANK_W-1:0] bank_o,
  output logic [DEPTH-1:0][COL_W-1:0]  col_o,
  output logic [DEPTH-1:0]             ap_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    logic              v_d, v_q, a_d, a_q;
    logic [BANK_W-1:0] b_d, b_q;
    logic [COL_W-1:0]  c_d, c_q;

    if (s == 0) begin : g_head
      assign v_d = vld_i;
      assign b_d = bank_i;
      assign c_d = col_i;
      assign a_d = ap_i;
    end else begin : g_tail
      assign v_d = vld_o[s-1];
      assign b_d = bank_o[s-1];
      assign c_d = col_o[s-1];
      assign a_d = ap_o[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        b_q <= '0;
        c_q <= '0;
        a_q <= 1'b0;
      end else begin
        v_q <= v_d;
        b_q <= b_d;
        c_q <= c_d;
        a_q <= a_d;
      end
    end

    assign vld_o[s]  = v_q;
    assign bank_o[s] = b_q;
    assign col_o[s]  = c_q;
    assign ap_o[s]   = a_q;
  end
endmodule

// File: rtl/ddr_rd_burst_gen.sv
module ddr_rd_burst_gen
  import ddr_rd_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  blen_e             blen_i,
  input  logic              launch_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  output logic              act_o,
  output logic              act_nxt_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_rise_o,
  output logic [COL_W-1:0]  col_fall_o,
  output logic              pre_req_o,
  output logic [BANK_W-1:0] pre_bank_o
);
  logic              act_q, ap_q, pre_q;
  logic [BANK_W-1:0] bank_q, pre_bank_q;
  logic [COL_W-1:0]  base_q;
  logic [PAIR_W-1:0] beat_q, last;
  logic [COL_W-1:0]  mask, off_r, off_f;
  logic              done;

  assign last  = last_pair(blen_i);
  assign done  = act_q && (beat_q == last);
  assign mask  = COL_W'({last, 1'b1});
  assign off_r = COL_W'({beat_q, 1'b0});
  assign off_f = COL_W'({beat_q, 1'b1});

  // sequential order, wrapping inside the aligned block
  assign col_rise_o = (base_q & ~mask) | ((base_q + off_r) & mask);
  assign col_fall_o = (base_q & ~mask) | ((base_q + off_f) & mask);

  assign act_nxt_o = launch_i | (act_q & ~done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      ap_q       <= 1'b0;
      bank_q     <= '0;
      base_q     <= '0;
      beat_q     <= '0;
      pre_q      <= 1'b0;
      pre_bank_q <= '0;
    end else begin
      // only a burst that reaches its last pair may request precharge
      pre_q      <= done & ap_q;
      pre_bank_q <= bank_q;
      if (launch_i) begin
        act_q  <= 1'b1;
        ap_q   <= ap_i;
        bank_q <= bank_i;
        base_q <= col_i;
        beat_q <= '0;
      end else if (done) begin
        act_q <= 1'b0;
        ap_q  <= 1'b0;
      end else if (act_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign act_o      = act_q;
  assign bank_o     = bank_q;
  assign pre_req_o  = pre_q;
  assign pre_bank_o = pre_bank_q;
endmodule

// File: rtl/ddr_rd_dq_fmt.sv
module ddr_rd_dq_fmt
  import ddr_rd_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int DQ_W  = 8
) (
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [1:0][COL_W-1:0]   col_i,
  output logic [1:0][DQ_W-1:0]    dq_o
);
  localparam int EXT_W = (COL_W > DQ_W) ? COL_W : DQ_W;

  logic [DQ_W-1:0] bank_mix;
  assign bank_mix = {bank_i, {(DQ_W-BANK_W){1'b0}}};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [EXT_W-1:0] ext;
    assign ext     = EXT_W'(col_i[l]);
    assign dq_o[l] = ext[DQ_W-1:0] ^ bank_mix;
  end
endmodule

// File: rtl/ddr_rd_strobe.sv
module ddr_rd_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upcoming_i,
  input  logic act_i,
  input  logic act_nxt_i,
  output logic dq_oe_o,
  output logic dqs_oe_o,
  output logic dqs_rise_o,
  output logic dqs_fall_o
);
  logic pre_q;

  // preamble only when the bus would otherwise be idle the cycle before data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= 1'b0;
    else         pre_q <= upcoming_i & ~act_nxt_i;
  end

  assign dq_oe_o    = act_i;
  assign dqs_oe_o   = act_i | pre_q;
  assign dqs_rise_o = act_i;
  assign dqs_fall_o = 1'b0;
endmodule

// File: rtl/ddr_rd_engine.sv
module ddr_rd_engine
  import ddr_rd_pkg::*;
#(
  parameter int COL_W  = 11,
  parameter int DQ_W   = 8,
  parameter int CL_MAX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl_sel_i,
  input  logic [1:0]        bl_sel_i,
  input  logic              cmd_rd_i,
  input  logic [1:0]        bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  output logic [DQ_W-1:0]   dq_rise_o,
  output logic [DQ_W-1:0]   dq_fall_o,
  output logic              dq_oe_o,
  output logic              dqs_rise_o,
  output logic              dqs_fall_o,
  output logic              dqs_oe_o,
  output logic              pre_req_o,
  output logic [1:0]        pre_bank_o
);
  localparam int PIPE_D = CL_MAX - 1;

  cas_e  cl;
  blen_e bl;
  assign cl = cas_e'(cl_sel_i);
  assign bl = blen_e'(bl_sel_i);

  logic [PIPE_D-1:0]             p_vld, p_ap;
  logic [PIPE_D-1:0][BANK_W-1:0] p_bank;
  logic [PIPE_D-1:0][COL_W-1:0]  p_col;

  ddr_rd_cmd_pipe #(.COL_W(COL_W), .DEPTH(PIPE_D)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (cmd_rd_i),
    .bank_i (bank_i),
    .col_i  (col_i),
    .ap_i   (ap_i),
    .vld_o  (p_vld),
    .bank_o (p_bank),
    .col_o  (p_col),
    .ap_o   (p_ap)
  );

  // launch stage: CL-2 registers after sampling
  logic upcoming, launch;
  assign launch   = (cl == CAS2) ? p_vld[0] : p_vld[1];
  assign upcoming = (cl == CAS2) ? cmd_rd_i : p_vld[0];

  logic              act, act_nxt;
  logic [BANK_W-1:0] cur_bank;
  logic [1:0][COL_W-1:0] cur_col;
  logic [1:0][DQ_W-1:0]  dq_pair;

  ddr_rd_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blen_i     (bl),
    .launch_i   (launch),
    .bank_i     (p_bank[cl_sel_i]),
    .col_i      (p_col[cl_sel_i]),
    .ap_i       (p_ap[cl_sel_i]),
    .act_o      (act),
    .act_nxt_o  (act_nxt),
    .bank_o     (cur_bank),
    .col_rise_o (cur_col[0]),
    .col_fall_o (cur_col[1]),
    .pre_req_o  (pre_req_o),
    .pre_bank_o (pre_bank_o)
  );

  ddr_rd_dq_fmt #(.COL_W(COL_W), .DQ_W(DQ_W)) u_fmt (
    .bank_i (cur_bank),
    .col_i  (cur_col),
    .dq_o   (dq_pair)
  );

  assign dq_rise_o = dq_pair[0];
  assign dq_fall_o = dq_pair[1];

  ddr_rd_strobe u_dqs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upcoming_i (upcoming),
    .act_i      (act),
    .act_nxt_i  (act_nxt),
    .dq_oe_o    (dq_oe_o),
    .dqs_oe_o   (dqs_oe_o),
    .dqs_rise_o (dqs_rise_o),
    .dqs_fall_o (dqs_fall_o)
  );
endmodule

// File: rtl/ddr_rd_engine_chk.sv
module ddr_rd_engine_chk #(
  parameter int COL_W = 11,
  parameter int DQ_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cl_sel_i,
  input logic [1:0]       bl_sel_i,
  input logic             cmd_rd_i,
  input logic [1:0]       bank_i,
  input logic [COL_W-1:0] col_i,
  input logic             ap_i,
  input logic [DQ_W-1:0]  dq_rise_o,
  input logic [DQ_W-1:0]  dq_fall_o,
  input logic             dq_oe_o,
  input logic             dqs_rise_o,
  input logic             dqs_fall_o,
  input logic             dqs_oe_o,
  input logic             pre_req_o,
  input logic [1:0]       pre_bank_o
);
  AST_LAT_CL2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_i && !cl_sel_i) |-> ##2 dq_oe_o); // R2
  AST_LAT_CL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_i && cl_sel_i) |-> ##3 dq_oe_o); // R2
  AST_DATA_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_oe_o && dqs_rise_o && !dqs_fall_o)); // R5
  AST_PREAMBLE_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_o && !dq_oe_o) |=> dq_oe_o); // R5
  AST_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> (!dq_oe_o && !dqs_rise_o)); // R6
  AST_PRE_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> $past(dq_oe_o)); // R8
endmodule

bind ddr_rd_engine ddr_rd_engine_chk #(.COL_W(COL_W), .DQ_W(DQ_W)) u_chk (.*);

// File: tb/sim_ddr_rd_engine.sv
module sim_ddr_rd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 11;
  localparam int DQ_W  = 8;
  localparam int NC    = 2048;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cl_sel_i = 1'b0;
  logic [1:0]       bl_sel_i = 2'd1;
  logic             cmd_rd_i = 1'b0;
  logic [1:0]       bank_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic             ap_i = 1'b0;
  logic [DQ_W-1:0]  dq_rise_o, dq_fall_o;
  logic             dq_oe_o, dqs_rise_o, dqs_fall_o, dqs_oe_o, pre_req_o;
  logic [1:0]       pre_bank_o;

  ddr_rd_engine #(.COL_W(COL_W), .DQ_W(DQ_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0, nrd = 0;
  bit fin = 1'b0;
  bit exp_oe [0:NC-1];
  bit exp_ap [0:NC-1];
  int exp_r [0:NC-1];
  int exp_f [0:NC-1];
  int exp_apb [0:NC-1];
  int ap_own [0:NC-1];
  int rd_last [0:255];

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic int ev(input int b, input int c);
    return ((c & 255) ^ (b << 6)) & 255;
  endfunction

  function automatic int cseq(input int c, input int i, input int blen);
    return (c & ~(blen - 1)) | ((c + i) & (blen - 1));
  endfunction

  // behavioural model: per-cycle expectation timeline
  task automatic sched(input int b, input int c, input bit ap);
    int d0, np, blen;
    d0 = cyc + (cl_sel_i ? 3 : 2);
    np = (bl_sel_i == 2'd0) ? 1 : (bl_sel_i == 2'd1) ? 2 : 4;
    blen = 2 * np;
    for (int k = 0; k < nrd; k++)
      if (rd_last[k] >= d0 && ap_own[rd_last[k] + 1] == k) exp_ap[rd_last[k] + 1] = 1'b0;
    for (int j = 0; j < np; j++) begin
      exp_oe[d0 + j] = 1'b1;
      exp_r[d0 + j]  = ev(b, cseq(c, 2 * j, blen));
      exp_f[d0 + j]  = ev(b, cseq(c, 2 * j + 1, blen));
    end
    if (ap) begin
      exp_ap[d0 + np]  = 1'b1;
      exp_apb[d0 + np] = b;
      ap_own[d0 + np]  = nrd;
    end
    rd_last[nrd] = d0 + np - 1;
    nrd++;
  endtask

  task automatic issue(input int b, input int c, input bit ap);
    @(negedge clk_i);
    cmd_rd_i = 1'b1;
    bank_i = 2'(b);
    col_i = COL_W'(c);
    ap_i = ap;
    sched(b, c, ap);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cmd_rd_i = 1'b0;
      ap_i = 1'b0;
    end
  endtask

  task automatic mode(input bit cl, input int bl);
    @(negedge clk_i);
    cmd_rd_i = 1'b0;
    cl_sel_i = cl;
    bl_sel_i = 2'(bl);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !fin && cyc < NC - 2) begin
      chk(dq_oe_o == exp_oe[cyc], "R6 R7 R2 dq_oe", int'(dq_oe_o), int'(exp_oe[cyc]));
      chk(dqs_oe_o == (exp_oe[cyc] | exp_oe[cyc + 1]), "R5 R6 dqs_oe",
          int'(dqs_oe_o), int'(exp_oe[cyc] | exp_oe[cyc + 1]));
      chk(dqs_rise_o == exp_oe[cyc], "R5 dqs_rise", int'(dqs_rise_o), int'(exp_oe[cyc]));
      chk(dqs_fall_o == 1'b0, "R5 dqs_fall", int'(dqs_fall_o), 0);
      if (exp_oe[cyc]) begin
        chk(int'(dq_rise_o) == exp_r[cyc], "R3 R4 dq_rise", int'(dq_rise_o), exp_r[cyc]);
        chk(int'(dq_fall_o) == exp_f[cyc], "R3 R4 dq_fall", int'(dq_fall_o), exp_f[cyc]);
      end
      chk(pre_req_o == exp_ap[cyc], "R8 R9 R10 pre_req", int'(pre_req_o), int'(exp_ap[cyc]));
      if (exp_ap[cyc])
        chk(int'(pre_bank_o) == exp_apb[cyc], "R8 pre_bank", int'(pre_bank_o), exp_apb[cyc]);
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    chk(!dq_oe_o && !dqs_oe_o && !dqs_rise_o && !pre_req_o, "R1 reset",
        int'({dq_oe_o, dqs_oe_o, dqs_rise_o, pre_req_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3);
    // R2 R3: CL2, BL4, wrap from column 6
    mode(1'b0, 1);
    issue(1, 6, 1'b0);
    idle(8);
    // R2 R8: CL3, BL8, unaligned start with auto precharge
    mode(1'b1, 2);
    issue(2, 13, 1'b1);
    idle(12);
    // R7 R8: BL2 every cycle, each completes
    mode(1'b0, 0);
    issue(0, 2, 1'b1);
    issue(1, 5, 1'b1);
    issue(2, 8, 1'b1);
    issue(3, 11, 1'b1);
    idle(8);
    // R7 R9: BL8 truncated after 2 pairs
    mode(1'b1, 2);
    issue(0, 16, 1'b1);
    idle(1);
    issue(3, 40, 1'b1);
    idle(12);
    // R7 R9: BL8 truncated after 3 pairs, CL2, reserved length code
    mode(1'b0, 3);
    issue(1, 71, 1'b1);
    idle(2);
    issue(2, 300, 1'b0);
    idle(12);
    // R8 R10: BL4 seamless chain after a complete burst
    mode(1'b0, 1);
    issue(1, 100, 1'b1);
    idle(1);
    issue(2, 203, 1'b0);
    idle(10);
    // R5: one idle cycle between bursts becomes a preamble
    issue(0, 20, 1'b0);
    idle(2);
    issue(1, 25, 1'b0);
    idle(10);
    // R7 R9: truncation every cycle at CL3
    mode(1'b1, 2);
    issue(3, 1000, 1'b1);
    issue(2, 1500, 1'b1);
    issue(1, 2047, 1'b1);
    idle(14);
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!fin) begin
      fin = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule